// File: doc/BRIEF.md
# Time Code Clock Discipline Controller

This block keeps a local time of day, held as a whole-seconds counter plus a microseconds counter, and steers it toward an external time reference. A base tick input advances the microseconds counter. At reset, the seconds counter takes a backup value that has only whole-second resolution, and the microseconds counter starts at zero. A stored frequency-correction constant, given in parts per million, can be applied from power-up. An accumulator then inserts or drops one tick from time to time, so that only the residual crystal error is left as drift.

Corrections arrive as an offset: reference time minus local time. The offset is split into a signed seconds part and a non-negative microseconds part. It arrives on a valid/ready stream. A transfer happens on a clock edge where both valid and ready are high. Ready is low for as long as a slew is in progress. While ready is low, the source must hold its offset; the offset is neither consumed nor acted upon.

An offset larger than 120 s in magnitude is applied in one step (jam). A smaller offset is removed gradually: one tick is doubled or dropped on every 30th base tick, so the slew takes about 30 times the offset. A stage output reports the synchronization stage. The stages are power-up, time lock, frequency lock and final lock.

Top module: `clk_discipline`

## Requirements
- R1: While reset is high and on the first cycle after it, `stage_o` is 0 (power-up) and `ofs_ready_o` is 1. Stage codes are: 0 power-up, 1 time lock, 2 frequency lock, 3 final lock.
- R2: Reset loads `sec_o` from `bkup_sec_i` and sets `usec_o` to 0.
- R3: With no correction active, each base tick adds 1 to `usec_o`. When `usec_o` would reach 1,000,000 it wraps and `sec_o` increments, so `usec_o` is always below 1,000,000. Without a tick and without an accepted offset, the time holds.
- R4: The stage stays 0, whatever the ticks, until the first offset is accepted. That transfer moves it to 1.
- R5: An offset is the value `ofs_sec_i` + `ofs_us_i`/1,000,000 s. An accepted offset whose magnitude exceeds 120 s adds itself to the local time on that edge (jam).
- R6: An accepted offset whose magnitude is at most 120 s leaves the time unchanged on the accepting edge. If it is non-zero, it starts a slew and drives `ofs_ready_o` low.
- R7: During a slew, every 30th base tick counted from acceptance advances time by 2 µs for a positive offset, or by 0 µs for a negative one. Each such event removes 1 µs of the offset. Ready returns high right after the event that removes the last microsecond.
- R8: While `ofs_ready_o` is low, an offset held on the stream is not accepted and changes neither time nor stage.
- R9: When `cst_vld_i` is 1, each tick adds |`cst_ppm_i`| (signed 8-bit) to an accumulator. Reaching PPM_SCALE (1,000,000) subtracts PPM_SCALE and doubles that tick for a positive constant, or drops it for a negative one. When `cst_vld_i` is 0 the constant has no effect.
- R10: If a frequency drop and a slew drop fall on the same tick, the frequency drop applies and the slew event moves to the next tick.
- R11: Time lock advances to frequency lock after DWELL_TICKS base ticks. These ticks are counted only while no slew is active.
- R12: In frequency lock, an accepted offset of magnitude at most FINE_US (10 µs) moves the stage to final lock. A larger slewed offset keeps it in frequency lock.
- R13: A jam in any stage returns the stage to time lock and restarts the dwell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Base microsecond tick strobe |
| bkup_sec_i | input | 32 | Whole-seconds backup time loaded at reset |
| cst_vld_i | input | 1 | A stored frequency constant is present |
| cst_ppm_i | input | 8 | Signed frequency constant in ppm |
| ofs_valid_i | input | 1 | Offset stream valid |
| ofs_ready_o | output | 1 | Offset stream ready (low while slewing) |
| ofs_sec_i | input | 32 | Signed seconds part of the offset |
| ofs_us_i | input | 20 | Microseconds part of the offset, 0 to 999,999 |
| sec_o | output | 32 | Local seconds |
| usec_o | output | 20 | Local microseconds |
| stage_o | output | 2 | Synchronization stage code |

## Verification
The frequency-correction drop and the slew drop can land on the same base tick, and the design must settle which one wins. The bench forces this case with a constant of -20 ppm at a reduced PPM_SCALE of 1000 and a 5 µs negative slew started right after reset. Both then fall due on the 150th tick. The result is judged at the ports: after 150 ticks, ready must still be low with `usec_o` at 143; after 151 ticks, ready must be high with `usec_o` still at 143.

// File: rtl/clk_discipline_pkg.sv
package clk_discipline_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_TLOCK = 2'd1,
    ST_FLOCK = 2'd2,
    ST_FINAL = 2'd3
  } stage_e;

  typedef struct packed {
    logic add;
    logic skip;
  } adj_t;
endpackage

// File: rtl/cd_offset_eval.sv
module cd_offset_eval #(
  parameter int SEC_W      = 32,
  parameter int US_W       = 20,
  parameter int MAG_W      = 27,
  parameter int US_PER_SEC = 1000000,
  parameter int JAM_SEC    = 120,
  parameter int FINE_US    = 10
) (
  input  logic signed [SEC_W-1:0] ofs_sec_i,
  input  logic [US_W-1:0]         ofs_us_i,
  output logic                    jam_o,
  output logic                    fine_o,
  output logic                    slow_o,
  output logic [MAG_W-1:0]        mag_o
);
  localparam logic signed [47:0] US_PS    = 48'(US_PER_SEC);
  localparam logic signed [47:0] JAM_LIM  = 48'(JAM_SEC) * 48'(US_PER_SEC);
  localparam logic signed [47:0] FINE_LIM = 48'(FINE_US);

  logic signed [47:0] sec_x, us_x, total, mag_full;
  logic unused_hi;

  assign sec_x    = 48'(ofs_sec_i);
  assign us_x     = 48'(ofs_us_i);
  assign total    = sec_x * US_PS + us_x;
  assign mag_full = total[47] ? -total : total;

  assign jam_o     = mag_full > JAM_LIM;
  assign fine_o    = mag_full <= FINE_LIM;
  assign slow_o    = !total[47];
  assign mag_o     = mag_full[MAG_W-1:0];
  assign unused_hi = ^mag_full[47:MAG_W];
endmodule

// File: rtl/cd_freq_acc.sv
module cd_freq_acc
  import clk_discipline_pkg::*;
#(
  parameter int PPM_W     = 8,
  parameter int PPM_SCALE = 1000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PPM_W-1:0] ppm_i,
  output adj_t             adj_o
);
  localparam int ACC_W = $clog2(PPM_SCALE + (2 ** PPM_W)) + 1;
  localparam logic [ACC_W-1:0] LIM = ACC_W'(PPM_SCALE);

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [PPM_W-1:0] mag;
  logic             neg, hit;

  assign neg     = ppm_i[PPM_W-1];
  assign mag     = neg ? (~ppm_i + PPM_W'(1)) : ppm_i;
  assign acc_sum = acc_q + ACC_W'(mag);
  assign hit     = tick_i && en_i && (acc_sum >= LIM);

  assign adj_o.add  = hit && !neg;
  assign adj_o.skip = hit && neg;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (tick_i && en_i) begin
      acc_q <= hit ? (acc_sum - LIM) : acc_sum;
    end
  end

  // R9
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q < LIM);
endmodule

// File: rtl/cd_slew.sv
module cd_slew
  import clk_discipline_pkg::*;
#(
  parameter int MAG_W    = 27,
  parameter int SLEW_DIV = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             slow_i,
  input  logic             fskip_i,
  output logic             busy_o,
  output adj_t             adj_o
);
  localparam int PH_W = $clog2(SLEW_DIV + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLEW_DIV - 1);

  logic [MAG_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic             slow_q, busy_q;
  logic             due, blocked, fire;

  assign due     = busy_q && tick_i && (ph_q == PH_LAST);
  assign blocked = !slow_q && fskip_i;
  assign fire    = due && !blocked;

  assign adj_o.add  = fire && slow_q;
  assign adj_o.skip = fire && !slow_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ph_q   <= '0;
      slow_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= mag_i;
      ph_q   <= '0;
      slow_q <= slow_i;
      busy_q <= (mag_i != '0);
    end else if (busy_q && tick_i) begin
      if (ph_q != PH_LAST) begin
        ph_q <= ph_q + PH_W'(1);
      end else if (!blocked) begin
        ph_q  <= '0;
        cnt_q <= cnt_q - MAG_W'(1);
        if (cnt_q == MAG_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  // R7
  slew_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(tick_i));
  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/cd_time_ctr.sv
module cd_time_ctr #(
  parameter int SEC_W      = 32,
  parameter int US_W       = 20,
  parameter int US_PER_SEC = 1000000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEC_W-1:0]        bkup_sec_i,
  input  logic [1:0]              step_i,
  input  logic                    jam_i,
  input  logic signed [SEC_W-1:0] jam_sec_i,
  input  logic [US_W-1:0]         jam_us_i,
  output logic [SEC_W-1:0]        sec_o,
  output logic [US_W-1:0]         us_o
);
  localparam logic [US_W+1:0] LIM = (US_W + 2)'(US_PER_SEC);

  logic [SEC_W-1:0] sec_q;
  logic [US_W-1:0]  us_q;
  logic [US_W+1:0]  us_adv, us_jam;

  assign us_adv = (US_W + 2)'(us_q) + (US_W + 2)'(step_i);
  assign us_jam = us_adv + (US_W + 2)'(jam_us_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= bkup_sec_i;
      us_q  <= '0;
    end else if (jam_i) begin
      if (us_jam >= LIM) begin
        us_q  <= US_W'(us_jam - LIM);
        sec_q <= sec_q + SEC_W'(jam_sec_i) + SEC_W'(1);
      end else begin
        us_q  <= US_W'(us_jam);
        sec_q <= sec_q + SEC_W'(jam_sec_i);
      end
    end else if (us_adv >= LIM) begin
      us_q  <= US_W'(us_adv - LIM);
      sec_q <= sec_q + SEC_W'(1);
    end else begin
      us_q <= US_W'(us_adv);
    end
  end

  assign sec_o = sec_q;
  assign us_o  = us_q;

  // R3
  us_range_chk: assert property (@(posedge clk) disable iff (rst)
    us_q < US_W'(US_PER_SEC));
endmodule

// File: rtl/clk_discipline.sv
module clk_discipline
  import clk_discipline_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int PPM_W       = 8,
  parameter int US_PER_SEC  = 1000000,
  parameter int PPM_SCALE   = 1000000,
  parameter int SLEW_DIV    = 30,
  parameter int JAM_SEC     = 120,
  parameter int FINE_US     = 10,
  parameter int DWELL_TICKS = 300000000,
  localparam int US_W       = $clog2(US_PER_SEC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic [SEC_W-1:0]        bkup_sec_i,
  input  logic                    cst_vld_i,
  input  logic [PPM_W-1:0]        cst_ppm_i,
  input  logic                    ofs_valid_i,
  output logic                    ofs_ready_o,
  input  logic signed [SEC_W-1:0] ofs_sec_i,
  input  logic [US_W-1:0]         ofs_us_i,
  output logic [SEC_W-1:0]        sec_o,
  output logic [US_W-1:0]         usec_o,
  output logic [1:0]              stage_o
);
  localparam int MAG_W = $clog2(JAM_SEC * US_PER_SEC + 1);
  localparam int DW_W  = $clog2(DWELL_TICKS + 1);
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL_TICKS - 1);

  stage_e           stage_q;
  logic [DW_W-1:0]  dwell_q;
  logic             accept, big, fine, slow, slew_busy;
  logic [MAG_W-1:0] mag;
  adj_t             f_adj, s_adj;
  logic [1:0]       step;

  assign ofs_ready_o = !slew_busy;
  assign accept      = ofs_valid_i && ofs_ready_o;

  cd_offset_eval #(
    .SEC_W(SEC_W), .US_W(US_W), .MAG_W(MAG_W), .US_PER_SEC(US_PER_SEC),
    .JAM_SEC(JAM_SEC), .FINE_US(FINE_US)
  ) u_eval (
    .ofs_sec_i(ofs_sec_i), .ofs_us_i(ofs_us_i),
    .jam_o(big), .fine_o(fine), .slow_o(slow), .mag_o(mag)
  );

  cd_freq_acc #(.PPM_W(PPM_W), .PPM_SCALE(PPM_SCALE)) u_freq (
    .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(cst_vld_i),
    .ppm_i(cst_ppm_i), .adj_o(f_adj)
  );

  cd_slew #(.MAG_W(MAG_W), .SLEW_DIV(SLEW_DIV)) u_slew (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(accept && !big),
    .mag_i(mag), .slow_i(slow), .fskip_i(f_adj.skip),
    .busy_o(slew_busy), .adj_o(s_adj)
  );

  always_comb begin
    int n;
    n = 1 + int'(f_adj.add) + int'(s_adj.add) - int'(f_adj.skip) - int'(s_adj.skip);
    step = tick_i ? 2'(n) : 2'd0;
  end

  cd_time_ctr #(.SEC_W(SEC_W), .US_W(US_W), .US_PER_SEC(US_PER_SEC)) u_time (
    .clk(clk), .rst(rst), .bkup_sec_i(bkup_sec_i), .step_i(step),
    .jam_i(accept && big), .jam_sec_i(ofs_sec_i), .jam_us_i(ofs_us_i),
    .sec_o(sec_o), .us_o(usec_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_PWRUP;
      dwell_q <= '0;
    end else if (accept) begin
      if (big || stage_q == ST_PWRUP) begin
        stage_q <= ST_TLOCK;
        dwell_q <= '0;
      end else if (stage_q == ST_FLOCK && fine) begin
        stage_q <= ST_FINAL;
      end
    end else if (tick_i && stage_q == ST_TLOCK && !slew_busy) begin
      if (dwell_q == DW_LAST) stage_q <= ST_FLOCK;
      else dwell_q <= dwell_q + DW_W'(1);
    end
  end

  assign stage_o = stage_q;

  // R11
  stage_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_q != $past(stage_q)) |-> (stage_q == ST_TLOCK || 2'(stage_q) == 2'($past(stage_q)) + 2'd1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !(ofs_valid_i && ofs_ready_o)) |=> ($stable(usec_o) && $stable(sec_o)));
  // R1
  ready_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (ofs_ready_o && stage_o == 2'd0));
endmodule

// File: tb/clk_discipline_tb.sv
module clk_discipline_tb;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cst_vld = 1'b0, ofs_valid = 1'b0, ofs_ready;
  logic [31:0] bkup = 32'd1000, sec;
  logic [7:0]  ppm = 8'd0;
  logic signed [31:0] ofs_sec = 32'sd0;
  logic [19:0] ofs_us = 20'd0, usec;
  logic [1:0]  stage;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  clk_discipline #(.PPM_SCALE(1000), .DWELL_TICKS(100)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .bkup_sec_i(bkup), .cst_vld_i(cst_vld),
    .cst_ppm_i(ppm), .ofs_valid_i(ofs_valid), .ofs_ready_o(ofs_ready),
    .ofs_sec_i(ofs_sec), .ofs_us_i(ofs_us), .sec_o(sec), .usec_o(usec), .stage_o(stage)
  );

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic v, logic [7:0] p);
    rst = 1'b1; cst_vld = v; ppm = p; ofs_valid = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send(int s, int u, int hold = 1);
    ofs_valid = 1'b1; ofs_sec = 32'(s); ofs_us = 20'(u);
    repeat (hold) @(negedge clk);
    ofs_valid = 1'b0;
  endtask

  task automatic t_reset_count;
    do_reset(1'b0, 8'd0);
    chk("R1 stage", stage, 0); chk("R1 ready", ofs_ready, 1);
    chk("R2 sec", sec, 1000); chk("R2 usec", usec, 0);
    ticks(10);
    chk("R3 usec", usec, 10); chk("R4 stage", stage, 0);
  endtask

  task automatic t_jam;
    do_reset(1'b0, 8'd0); ticks(10);
    send(200, 500);
    chk("R5 sec", sec, 1200); chk("R5 usec", usec, 510); chk("R4 stage", stage, 1);
    send(120, 1);
    chk("R5 edge sec", sec, 1320); chk("R5 edge usec", usec, 511);
    send(120, 0);
    chk("R6 ready", ofs_ready, 0); chk("R6 sec", sec, 1320); chk("R6 usec", usec, 511);
    do_reset(1'b0, 8'd0);
    send(-121, 500000);
    chk("R5 neg sec", sec, 879); chk("R5 neg usec", usec, 500000);
    do_reset(1'b0, 8'd0);
    send(-120, 0);
    chk("R6 neg ready", ofs_ready, 0); chk("R6 neg sec", sec, 1000);
  endtask

  task automatic t_rollover;
    do_reset(1'b0, 8'd0);
    send(200, 999998);
    ticks(3);
    chk("R3 wrap sec", sec, 1201); chk("R3 wrap usec", usec, 1);
  endtask

  task automatic t_slew;
    do_reset(1'b0, 8'd0);
    send(0, 3);
    ticks(29); chk("R7 usec29", usec, 29);
    ticks(1);  chk("R7 usec30", usec, 31);
    ticks(59); chk("R7 busy", ofs_ready, 0);
    ticks(1);  chk("R7 usec90", usec, 93); chk("R7 done", ofs_ready, 1);
    do_reset(1'b0, 8'd0);
    send(-1, 999998);
    ticks(60); chk("R7 neg usec", usec, 58); chk("R7 neg done", ofs_ready, 1);
  endtask

  task automatic t_backpressure;
    do_reset(1'b0, 8'd0);
    send(0, 3);
    send(500, 0, 4);
    chk("R8 sec", sec, 1000); chk("R8 usec", usec, 0); chk("R8 stage", stage, 1);
    ticks(90);
    chk("R8 usec after", usec, 93); chk("R8 ready", ofs_ready, 1); chk("R8 sec after", sec, 1000);
  endtask

  task automatic t_freq;
    do_reset(1'b1, 8'd20);
    ticks(49); chk("R9 pos49", usec, 49);
    ticks(1);  chk("R9 pos50", usec, 51);
    do_reset(1'b1, 8'hEC);
    ticks(50); chk("R9 neg50", usec, 49);
    do_reset(1'b0, 8'd20);
    ticks(50); chk("R9 off50", usec, 50);
  endtask

  task automatic t_collide;
    do_reset(1'b1, 8'hEC);
    send(-1, 999995);
    ticks(150);
    chk("R10 ready150", ofs_ready, 0); chk("R10 usec150", usec, 143);
    ticks(1);
    chk("R10 ready151", ofs_ready, 1); chk("R10 usec151", usec, 143);
  endtask

  task automatic t_stages;
    do_reset(1'b0, 8'd0);
    send(0, 0);
    chk("R4 tlock", stage, 1); chk("R6 zero ready", ofs_ready, 1);
    ticks(99); chk("R11 dwell99", stage, 1);
    ticks(1);  chk("R11 dwell100", stage, 2);
    send(0, 20);
    chk("R12 coarse", stage, 2);
    ticks(600); chk("R12 ready", ofs_ready, 1);
    send(0, 5);
    chk("R12 final", stage, 3);
    ticks(150);
    send(200, 0);
    chk("R13 back", stage, 1);
    ticks(99); chk("R13 dwell99", stage, 1);
    ticks(1);  chk("R13 dwell100", stage, 2);
    do_reset(1'b0, 8'd0);
    send(0, 2);
    ticks(159); chk("R11 paused159", stage, 1);
    ticks(1);   chk("R11 paused160", stage, 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset_count();
    t_jam();
    t_rollover();
    t_slew();
    t_backpressure();
    t_freq();
    t_collide();
    t_stages();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule